// File: doc/BRIEF.md
# Sticky Serial 1-1-0 Detector

This block watches a serial stream that delivers one bit on every rising clock edge. It looks for two consecutive ones followed by a zero, taken oldest bit first. The detect output rises while that closing zero is still on the input, before the edge that samples it. After that the output stays high on every cycle, whatever the input does, until a synchronous reset. A controller can use it as a one-shot flag that records that the pattern has occurred at least once since reset.

Inside, a four-state machine keeps the progress through the pattern. The states are idle, one 1 seen, two 1s seen (armed), and a terminal locked state. The output is decoded from the current state and the live input bit. Any number of extra ones while armed keeps the machine armed. A zero that comes after a single one, or a zero in idle, sends it back to idle.

Top module: `seq110_detector`

## Requirements
- R1: While `rst_i` is high at a rising edge the machine goes to idle. In idle, `hit_o` is 0 for either input value.
- R2: Exactly one bit of `bit_i` is taken at each rising edge. A 1 held for one edge and followed by a 0 is one 1 and does not complete the pattern.
- R3: When the two bits sampled at the last two edges were both 1 with no reset between, `hit_o` is 1 in the same cycle that `bit_i` is 0, before the next edge.
- R4: Once `hit_o` has been 1, it stays 1 at every later cycle, for any `bit_i`, until a reset edge.
- R5: While armed, further 1s keep the machine armed, so 1,1,1,1,0 asserts `hit_o` on the final 0.
- R6: A 0 that follows a single 1, or a 0 in idle, returns the machine to idle. Ones sampled before that 0 do not count toward a later match.
- R7: A reset edge clears both the locked and the armed condition. After it, a lone 0 does not assert `hit_o`.
- R8: Before the first match, `hit_o` is 0 in every cycle where `bit_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; input sampled on rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| bit_i | input | 1 | Serial data bit, one per cycle |
| hit_o | output | 1 | Detect flag, sticky until reset |

## Verification
The only result is `hit_o`, and it is due in the same cycle as the bit that causes it. The path is combinational from `bit_i` and the state register, with no register in between. The bench therefore drives each bit at the falling edge and samples `hit_o` 1 ns later, before the rising edge that takes that bit in. The effect of a reset shows in the cycle after its rising edge, so reset checks sample after the falling edge that follows the release of reset.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'd0,
        ST_ONE    = 2'd1,
        ST_ARMED  = 2'd2,
        ST_LOCKED = 2'd3
    } det_state_e;

    // Transition function of the pattern tracker.
    function automatic det_state_e step(input det_state_e cur, input logic b);
        det_state_e nxt;
        unique case (cur)
            ST_IDLE:   nxt = b ? ST_ONE    : ST_IDLE;
            ST_ONE:    nxt = b ? ST_ARMED  : ST_IDLE;
            ST_ARMED:  nxt = b ? ST_ARMED  : ST_LOCKED;
            ST_LOCKED: nxt = ST_LOCKED;
            default:   nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    // Output decode: locked, or armed with the closing zero present.
    function automatic logic flag(input det_state_e cur, input logic b);
        return (cur == ST_LOCKED) || ((cur == ST_ARMED) && !b);
    endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
    import seqdet_pkg::*;
(
    input  det_state_e cur_i,
    input  logic       bit_i,
    output det_state_e nxt_o
);
    always_comb begin
        nxt_o = step(cur_i, bit_i);
    end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
    import seqdet_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  det_state_e nxt_i,
    output det_state_e cur_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) cur_o <= ST_IDLE;
        else       cur_o <= nxt_i;
    end
endmodule

// File: rtl/seqdet_out.sv
module seqdet_out
    import seqdet_pkg::*;
(
    input  det_state_e cur_i,
    input  logic       bit_i,
    output logic       hit_o
);
    always_comb begin
        hit_o = flag(cur_i, bit_i);
    end
endmodule

// File: rtl/seq110_detector.sv
module seq110_detector
    import seqdet_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic hit_o
);
    det_state_e state_q;
    det_state_e state_d;

    seqdet_next u_next (
        .cur_i (state_q),
        .bit_i (bit_i),
        .nxt_o (state_d)
    );

    seqdet_state_reg u_reg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .nxt_i (state_d),
        .cur_o (state_q)
    );

    seqdet_out u_out (
        .cur_i (state_q),
        .bit_i (bit_i),
        .hit_o (hit_o)
    );
endmodule

// File: rtl/seq110_detector_chk.sv
module seq110_detector_chk
    import seqdet_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       bit_i,
    input logic       hit_o,
    input det_state_e st
);
    // R1: the cycle after a reset edge is idle, so no flag.
    assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !hit_o);

    // R3: two 1s then a live 0 flags at once.
    assert_flag_on_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(rst_i, 2) && $past(bit_i) && $past(bit_i, 2) && !bit_i)
        |-> hit_o);

    // R4: flag is sticky.
    assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> hit_o);

    // R5: armed plus a 1 stays armed.
    assert_armed_holds_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_ARMED && bit_i) |=> (st == ST_ARMED));

    // R6: a 0 while in the single-one state goes back to idle.
    assert_single_one_drop_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_ONE && !bit_i) |=> (st == ST_IDLE));

    // R8: a new flag never rises while the input is 1.
    assert_no_rise_on_one_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $rose(hit_o)) |-> !bit_i);
endmodule

bind seq110_detector seq110_detector_chk u_chk (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .bit_i (bit_i),
    .hit_o (hit_o),
    .st    (state_q)
);

// File: tb/seq110_detector_tb.sv
`timescale 1ns/1ps
module seq110_detector_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit;
    int   n_checks = 0;
    int   n_errors = 0;

    always #5 clk = ~clk;

    seq110_detector dut_i (
        .clk_i (clk),
        .rst_i (rst),
        .bit_i (din),
        .hit_o (hit)
    );

    task automatic check(input logic exp, input string tag);
        n_checks++;
        if (hit !== exp) begin
            n_errors++;
            $display("FAIL %s: hit_o actual=%b expected=%b", tag, hit, exp);
        end
    endtask

    // Drive one bit after the falling edge, sample before the rising edge.
    task automatic feed(input logic b, input logic exp, input string tag);
        @(negedge clk);
        din = b;
        #1;
        check(exp, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(1'b0, tag);
    endtask

    task automatic t_basic;
        do_reset("R1 reset state");
        feed(1, 0, "R8 first one");
        feed(1, 0, "R8 second one");
        feed(0, 1, "R3 flag on closing zero");
        feed(0, 1, "R4 sticky on zero");
        feed(1, 1, "R4 sticky on one");
        feed(0, 1, "R4 sticky later");
        feed(1, 1, "R4 sticky end");
    endtask

    task automatic t_long_run;
        do_reset("R1 reset before run");
        feed(1, 0, "R5 run bit 1");
        feed(1, 0, "R5 run bit 2");
        feed(1, 0, "R5 run bit 3");
        feed(1, 0, "R5 run bit 4");
        feed(0, 1, "R5 flag after long run");
    endtask

    task automatic t_single_one;
        do_reset("R1 reset before single");
        feed(1, 0, "R2 lone one");
        feed(0, 0, "R2 one then zero no flag");
        feed(1, 0, "R6 one after drop");
        feed(0, 0, "R6 drop again");
        feed(0, 0, "R6 zero in idle");
        feed(1, 0, "R6 fresh one");
        feed(1, 0, "R6 fresh two");
        feed(0, 1, "R6 flag after fresh pair");
    endtask

    task automatic t_idle_zeros;
        do_reset("R1 reset before zeros");
        feed(0, 0, "R6 idle zero a");
        feed(0, 0, "R6 idle zero b");
        feed(1, 0, "R8 one from idle");
        feed(1, 0, "R8 armed one");
    endtask

    task automatic t_reset_clears;
        do_reset("R7 clear armed");
        feed(0, 0, "R7 zero after armed cleared");
        feed(1, 0, "R7 relock one");
        feed(1, 0, "R7 relock two");
        feed(0, 1, "R7 relocked");
        do_reset("R7 clear locked");
        feed(0, 0, "R7 zero after lock cleared");
        feed(1, 0, "R7 one after lock cleared");
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_basic();
        t_long_run();
        t_single_one();
        t_idle_zeros();   // leaves machine armed for next task
        t_reset_clears();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule